// File: doc/BRIEF.md
# Single-Level Fixed-Priority Interrupt Controller

This block gathers five interrupt sources and hands the CPU one vector at a time. The sources are two external pins, a counter/timer overflow, a watchdog timer overflow and a serial-bus unit request. Each source has its own enable bit, and one global enable gates all of them. When any enabled source is pending and no handler is running, the block picks the winner in a hard-wired order. It then emits a one-cycle request strobe together with the vector address of that source.

There is only one service level, and there is no priority register. An in-service flag is set when a vector is issued. It blocks every further request until the CPU sends a return-from-interrupt pulse. Each external pin can work in one of two ways: level-sensitive (active low), or falling-edge-sensitive with the pin sampled once per machine cycle. A wake output tells the power-management logic that some enabled source is pending, so that idle mode can end.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `in_service` is 1, `irq_req` stays 0. A `reti_pulse` clears `in_service` at the next clock edge. A `reti_pulse` while `in_service` is 0 has no effect.
- R2: When several enabled sources are pending, the winner follows this order, highest first: external pin 0, counter/timer 0, external pin 1, watchdog timer, serial unit.
- R3: Vector addresses are 0x003 (external pin 0), 0x00B (counter/timer 0), 0x013 (external pin 1), 0x01B (watchdog) and 0x023 (serial unit).
- R4: After reset, `irq_req` is 0, `in_service` is 0, `wake` is 0 and `irq_vec` holds the reset vector 0x000.
- R5: `src_en` bit 0 enables external pin 0, bit 1 counter/timer 0, bit 2 external pin 1, bit 3 watchdog and bit 4 the serial unit. A source takes part only if its bit is 1 and `glb_en` is 1.
- R6: `wake` is 1 in the same cycle that any source is pending with its enable bit and `glb_en` both 1. It is 0 whenever `glb_en` is 0.
- R7: A one-cycle pulse on `tmr0_ovf` or `wdt_ovf` sets a pending flag. Hardware clears that flag when its vector is issued. The flag stays set while its source is disabled.
- R8: The serial-unit request follows the `i2c_req` level and is never cleared by the block. It is issued again after each return for as long as `i2c_req` is held at 1.
- R9: With `ext0_edge`/`ext1_edge` at 0, the matching pin requests while it is low and releases the request when it goes high. Nothing is latched.
- R10: With the edge select at 1, a high-to-low change of the pin is seen at the machine-cycle sample rate. It is latched as pending, and it is cleared when its vector is issued. A pin held low raises only one request.
- R11: A vector is issued at the clock edge after an enabled request becomes visible. At that edge `irq_req` rises for exactly one cycle, `in_service` rises and `irq_vec` updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_pin | input | 1 | External interrupt pin 0, active low |
| ext1_pin | input | 1 | External interrupt pin 1, active low |
| ext0_edge | input | 1 | 1 selects falling-edge mode for pin 0 |
| ext1_edge | input | 1 | 1 selects falling-edge mode for pin 1 |
| tmr0_ovf | input | 1 | Counter/timer 0 overflow pulse |
| wdt_ovf | input | 1 | Watchdog timer overflow pulse |
| i2c_req | input | 1 | Serial unit request level |
| src_en | input | 5 | Per-source enable bits |
| glb_en | input | 1 | Global enable |
| reti_pulse | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | One-cycle vector strobe |
| irq_vec | output | 12 | Vector address |
| in_service | output | 1 | A handler is active |
| wake | output | 1 | Enabled request pending; ends idle |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `reti_pulse` is the only thing that ends a service level, so the block can never issue two vectors without a return between them. The bench changes inputs only on falling edges. It raises the global enable only after the timer pulses have been latched and the pins have been driven, so each table row starts from a known pending set. It sends returns only while a handler is active, except in the one test that checks a stray return is ignored.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 5;
  localparam int VEC_W = 12;

  typedef enum logic [2:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_WDT  = 3'd3,
    SRC_I2C  = 3'd4
  } src_e;

  localparam logic [VEC_W-1:0] RESET_VEC = '0;

  // vectors sit 8 bytes apart starting at 0x003
  function automatic logic [VEC_W-1:0] vec_of(input logic [2:0] idx);
    return VEC_W'(3) + (VEC_W'(idx) << 3);
  endfunction
endpackage

// File: rtl/irq_mc_tick.sv
module irq_mc_tick #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/irq_ext_detect.sv
module irq_ext_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic samp_q, samp_d;
  logic fall_q, fall_d;
  logic fall_seen;

  assign fall_seen = tick && edge_mode && samp_q && !pin;

  always_comb begin
    samp_d = tick ? pin : samp_q;
    fall_d = fall_q;
    if (clr)       fall_d = 1'b0;
    if (fall_seen) fall_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      fall_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      fall_q <= fall_d;
    end
  end

  assign req = edge_mode ? fall_q : !pin;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [2:0]       idx,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = 3'(i);
    end
  end

  assign any = |req;
  assign vec = vec_of(idx);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int MC_DIV = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext0_pin,
  input  logic             ext1_pin,
  input  logic             ext0_edge,
  input  logic             ext1_edge,
  input  logic             tmr0_ovf,
  input  logic             wdt_ovf,
  input  logic             i2c_req,
  input  logic [NSRC-1:0]  src_en,
  input  logic             glb_en,
  input  logic             reti_pulse,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             in_service,
  output logic             wake
);
  logic            mc_tick;
  logic [NSRC-1:0] raw_req, live_req, clr_vec;
  logic            win_any;
  logic [2:0]      win_idx;
  logic [VEC_W-1:0] win_vec;
  logic            issue;

  logic             tmr_pend_q, tmr_pend_d;
  logic             wdt_pend_q, wdt_pend_d;
  logic             svc_q, svc_d;
  logic             strb_q, strb_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  irq_mc_tick #(.DIV(MC_DIV)) i_tick (
    .clk(clk), .rst_n(rst_n), .tick(mc_tick)
  );

  logic [1:0] ext_pin, ext_mode, ext_req, ext_clr;
  assign ext_pin  = {ext1_pin, ext0_pin};
  assign ext_mode = {ext1_edge, ext0_edge};
  assign ext_clr  = {clr_vec[SRC_EXT1], clr_vec[SRC_EXT0]};

  for (genvar g = 0; g < 2; g++) begin : g_ext
    irq_ext_detect i_det (
      .clk(clk), .rst_n(rst_n), .tick(mc_tick),
      .pin(ext_pin[g]), .edge_mode(ext_mode[g]),
      .clr(ext_clr[g]), .req(ext_req[g])
    );
  end

  always_comb begin
    raw_req           = '0;
    raw_req[SRC_EXT0] = ext_req[0];
    raw_req[SRC_TMR0] = tmr_pend_q;
    raw_req[SRC_EXT1] = ext_req[1];
    raw_req[SRC_WDT]  = wdt_pend_q;
    raw_req[SRC_I2C]  = i2c_req;
  end

  assign live_req = raw_req & src_en & {NSRC{glb_en}};

  irq_pick #(.N(NSRC)) i_pick (
    .req(live_req), .any(win_any), .idx(win_idx), .vec(win_vec)
  );

  assign issue = win_any && !svc_q;

  always_comb begin
    clr_vec = '0;
    if (issue) clr_vec[win_idx] = 1'b1;
  end

  always_comb begin
    tmr_pend_d = tmr_pend_q;
    if (clr_vec[SRC_TMR0]) tmr_pend_d = 1'b0;
    if (tmr0_ovf)          tmr_pend_d = 1'b1;

    wdt_pend_d = wdt_pend_q;
    if (clr_vec[SRC_WDT])  wdt_pend_d = 1'b0;
    if (wdt_ovf)           wdt_pend_d = 1'b1;

    svc_d  = svc_q;
    strb_d = 1'b0;
    vec_d  = vec_q;
    if (issue) begin
      svc_d  = 1'b1;
      strb_d = 1'b1;
      vec_d  = win_vec;
    end else if (svc_q && reti_pulse) begin
      svc_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_pend_q <= 1'b0;
      wdt_pend_q <= 1'b0;
      svc_q      <= 1'b0;
      strb_q     <= 1'b0;
      vec_q      <= RESET_VEC;
    end else begin
      tmr_pend_q <= tmr_pend_d;
      wdt_pend_q <= wdt_pend_d;
      svc_q      <= svc_d;
      strb_q     <= strb_d;
      vec_q      <= vec_d;
    end
  end

  assign irq_req    = strb_q;
  assign irq_vec    = vec_q;
  assign in_service = svc_q;
  assign wake       = win_any;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        glb_en,
  input logic        reti_pulse,
  input logic        irq_req,
  input logic [11:0] irq_vec,
  input logic        in_service,
  input logic        wake
);
  p_no_nest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_service |=> !irq_req);

  p_reti_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && reti_pulse) |=> !in_service);

  p_vec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec == 12'h003 || irq_vec == 12'h00B || irq_vec == 12'h013 ||
                 irq_vec == 12'h01B || irq_vec == 12'h023));

  p_wake_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !wake);

  p_strobe_svc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (in_service && $rose(in_service)));

  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  p_vec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> $stable(irq_vec));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .reti_pulse(reti_pulse),
  .irq_req(irq_req), .irq_vec(irq_vec), .in_service(in_service), .wake(wake)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext0_pin, ext1_pin, ext0_edge, ext1_edge;
  logic        tmr0_ovf, wdt_ovf, i2c_req, glb_en, reti_pulse;
  logic [4:0]  src_en;
  logic        irq_req, in_service, wake;
  logic [11:0] irq_vec;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.MC_DIV(4)) i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ext0_pin(ext0_pin), .ext1_pin(ext1_pin),
    .ext0_edge(ext0_edge), .ext1_edge(ext1_edge),
    .tmr0_ovf(tmr0_ovf), .wdt_ovf(wdt_ovf), .i2c_req(i2c_req),
    .src_en(src_en), .glb_en(glb_en), .reti_pulse(reti_pulse),
    .irq_req(irq_req), .irq_vec(irq_vec),
    .in_service(in_service), .wake(wake)
  );

  // row: {active[4:0], en[4:0], glb, exp_req, exp_vec[11:0]}
  // active/en bit order: 0 ext0, 1 tmr0, 2 ext1, 3 wdt, 4 i2c
  localparam int NV = 12;
  localparam logic [23:0] TBL [NV] = '{
    {5'b11111, 5'b11111, 1'b1, 1'b1, 12'h003},
    {5'b11111, 5'b11110, 1'b1, 1'b1, 12'h00B},
    {5'b11111, 5'b11100, 1'b1, 1'b1, 12'h013},
    {5'b11111, 5'b11000, 1'b1, 1'b1, 12'h01B},
    {5'b11111, 5'b10000, 1'b1, 1'b1, 12'h023},
    {5'b11111, 5'b11111, 1'b0, 1'b0, 12'h000},
    {5'b00000, 5'b11111, 1'b1, 1'b0, 12'h000},
    {5'b10000, 5'b11111, 1'b1, 1'b1, 12'h023},
    {5'b11000, 5'b11111, 1'b1, 1'b1, 12'h01B},
    {5'b10100, 5'b11111, 1'b1, 1'b1, 12'h013},
    {5'b00010, 5'b00010, 1'b1, 1'b1, 12'h00B},
    {5'b11111, 5'b00000, 1'b1, 1'b0, 12'h000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ext0_pin = 1'b1; ext1_pin = 1'b1; ext0_edge = 1'b0; ext1_edge = 1'b0;
    tmr0_ovf = 1'b0; wdt_ovf = 1'b0; i2c_req = 1'b0;
    src_en = '0; glb_en = 1'b0; reti_pulse = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic watch(input int n, output int cnt, output logic [11:0] last);
    cnt = 0; last = '0;
    repeat (n) begin
      @(negedge clk);
      if (irq_req) begin cnt++; last = irq_vec; end
    end
  endtask

  task automatic give_reti();
    reti_pulse = 1'b1;
    @(negedge clk);
    reti_pulse = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    logic [11:0] lv;
    rst_n = 1'b0;
    idle_inputs();

    // R4 reset state
    do_reset();
    #1;
    check("R4 irq_req", irq_req, 0);
    check("R4 in_service", in_service, 0);
    check("R4 wake", wake, 0);
    check("R4 irq_vec", irq_vec, 12'h000);

    // R2 R3 R5 R6 R11 table walk
    for (int i = 0; i < NV; i++) begin
      logic [4:0] a, e;
      logic g, xr;
      logic [11:0] xv;
      {a, e, g, xr, xv} = TBL[i];
      do_reset();
      src_en = e; glb_en = 1'b0;
      ext0_pin = ~a[0]; tmr0_ovf = a[1]; ext1_pin = ~a[2];
      wdt_ovf = a[3]; i2c_req = a[4];
      @(negedge clk);
      tmr0_ovf = 1'b0; wdt_ovf = 1'b0; glb_en = g;
      #1 check($sformatf("R6 wake row %0d", i), wake, g & (|(a & e)));
      @(negedge clk);
      check($sformatf("R2/R5/R11 irq_req row %0d", i), irq_req, xr);
      check($sformatf("R3 irq_vec row %0d", i), irq_vec, xv);
    end

    // R1 R9 no nesting, level pins
    do_reset();
    src_en = 5'b11111; glb_en = 1'b1; ext1_pin = 1'b0;
    @(negedge clk);
    check("R9 ext1 level vec", irq_vec, 12'h013);
    ext0_pin = 1'b0;
    watch(6, cnt, lv);
    check("R1 no request while in service", cnt, 0);
    check("R1 in_service held", in_service, 1);
    ext1_pin = 1'b1;
    give_reti();
    check("R1 released by return", in_service, 0);
    @(negedge clk);
    check("R1/R2 pending ext0 after return", irq_req, 1);
    check("R3 ext0 vec", irq_vec, 12'h003);
    give_reti();
    @(negedge clk);
    check("R9 level still low reissues", irq_req, 1);
    ext0_pin = 1'b1;
    give_reti();
    watch(6, cnt, lv);
    check("R9 released pin no request", cnt, 0);

    // R7 timer flag cleared on take
    do_reset();
    src_en = 5'b11111; glb_en = 1'b1; tmr0_ovf = 1'b1;
    @(negedge clk);
    tmr0_ovf = 1'b0;
    @(negedge clk);
    check("R7 timer vector", irq_vec, 12'h00B);
    give_reti();
    watch(6, cnt, lv);
    check("R7 timer flag cleared", cnt, 0);

    // R7 latched while disabled
    do_reset();
    src_en = 5'b10101; glb_en = 1'b1; wdt_ovf = 1'b1;
    @(negedge clk);
    wdt_ovf = 1'b0;
    watch(5, cnt, lv);
    check("R7 disabled no request", cnt, 0);
    check("R6 disabled no wake", wake, 0);
    src_en = 5'b11111;
    #1 check("R6 wake on enable", wake, 1);
    @(negedge clk);
    check("R7 latched watchdog issued", irq_req, 1);
    check("R3 watchdog vec", irq_vec, 12'h01B);

    // R8 serial request persists
    do_reset();
    src_en = 5'b11111; glb_en = 1'b1; i2c_req = 1'b1;
    @(negedge clk);
    check("R8 serial vector", irq_vec, 12'h023);
    give_reti();
    watch(3, cnt, lv);
    check("R8 serial reissued", cnt, 1);

    // R10 edge mode
    do_reset();
    ext0_edge = 1'b1; src_en = 5'b11111; glb_en = 1'b1;
    watch(6, cnt, lv);
    ext0_pin = 1'b0;
    watch(12, cnt, lv);
    check("R10 one request on falling edge", cnt, 1);
    check("R10 edge vec", lv, 12'h003);
    give_reti();
    watch(12, cnt, lv);
    check("R10 held low no repeat", cnt, 0);

    // R1 stray return ignored
    do_reset();
    give_reti();
    check("R1 stray return in_service", in_service, 0);
    watch(3, cnt, lv);
    check("R1 stray return irq", cnt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule